// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a 64-bit effective address into a real address by walking in-memory translation tables. A request carries the address, the access kind, a few machine-state and partition-control bits, the partition-table base, a partition id and a process id. First the walker fetches the partition-table entry, which yields the process-table base. Next it fetches the process-table entry, which yields the root of a radix tree, the root level's index width and the total count of translated address bits. It then descends the tree one level per memory read. Each directory entry names the next level's base and index width, so the depth and the level widths vary from one tree to another.

All table words are held big-endian in memory and are byte-reversed on arrival. Memory is reached through a single-outstanding 64-bit read port. Each walk ends with one response: either a real address together with the final leaf entry, or a fault with a syndrome word that tells a process-table fault, an unsupported tree shape and a missing translation apart. Access-permission checks on the leaf are done by a separate checker, which receives the leaf through `resp_pte`.

Top module: `radix_walker`

## Requirements
- R1: When a request is accepted with (`lpcr_hr`=0 and `lpcr_vc`<=3) or (`msr_hv`=1, `msr_pr`=0, `msr_dr`=0), no memory read is issued, and in the next cycle `done` pulses with `resp_fault`=1 and syndrome bit 17 set.
- R2: The first read goes to (`ptab_base` with its low 12 bits cleared) + `req_lpid`*16 + 8. The process-table base is that word ANDed with 0x0FFFFFFFFFFFF000. The second read goes to that base + `req_pid`*16.
- R3: Every word returned on `mem_rdata` is byte-reversed before use: bits [7:0] become bits [63:56], and so on for each byte.
- R4: From the process-table entry e: root base = e & 0x0FFFFFFFFFFFFF00, root index width = e[4:0], translated bit count U = 31 + {e[62:61], e[7:5]}.
- R5: A level of index width s, with U bits still untranslated, reads at base + 8*EA[U-1:U-s].
- R6: A level with width below 5, with width greater than the remaining U, or past the fourth level faults with syndrome bit 19, and no read is issued for that level.
- R7: A tree entry with bit 63 = 0 is invalid. If `lpcr_hr`=0 it faults with bit 17. Otherwise, if `msr_dr` or `msr_ir` is 1, it faults with bit 30. Otherwise the walk completes without fault and `resp_ra` equals the effective address.
- R8: A valid entry with bit 62 = 1 is a leaf. With m = 2^(U-s)-1 for that level, `resp_ra` = (e & 0x01FFFFFFFFFFF000 & ~m) | (EA & m), and `resp_pte` is the byte-reversed entry.
- R9: A valid non-leaf entry e sets the next base to e & 0x00FFFFFFFFFFFF00 and the next width to e[4:0], and reduces U by the current width.
- R10: `req_mode` encodes 0 = load, 1 = store, 2 = fetch. Any fault raised for a store also sets syndrome bit 25.
- R11: A request is taken only while `req_ready`=1 (idle). Each walk gives exactly one one-cycle `done` pulse. At most one read is outstanding, and `mem_addr` holds steady until `mem_rvalid`.
- R12: After reset `done`=0, `mem_req`=0 and `req_ready`=1. On any fault `resp_ra` equals the effective address. A fault-free response has a zero syndrome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Walker idle |
| req_ea | input | 64 | Effective address |
| req_mode | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| msr_hv | input | 1 | Hypervisor state bit |
| msr_pr | input | 1 | Problem (user) state bit |
| msr_dr | input | 1 | Data relocation enabled |
| msr_ir | input | 1 | Instruction relocation enabled |
| lpcr_hr | input | 1 | Radix host translation enabled |
| lpcr_vc | input | 3 | Virtualization control field |
| ptab_base | input | 64 | Partition-table base |
| req_lpid | input | 12 | Partition id |
| req_pid | input | 20 | Process id |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 64 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, big-endian |
| done | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Walk faulted |
| resp_syndrome | output | 64 | Fault syndrome bits |
| resp_ra | output | 64 | Real address (effective address on fault) |
| resp_pte | output | 64 | Byte-reversed leaf entry for permission checking |

## Verification
The assertions assume that the memory side answers each read with exactly one `mem_rvalid` pulse, and only after a `mem_req`. They also assume that `mem_rvalid` never arrives unprompted, since the walker relies on it to advance. The bench's memory responder answers each request once, after a fixed two-cycle latency. It returns zero for addresses it was never given, so those reads decode as invalid entries. Requests are sent only from the idle state, with one deliberate exception that checks that a request raised mid-walk is ignored.

// File: rtl/rw_pkg.sv
package rw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PATE,
      ST_PRTE,
      ST_LVL,
      ST_LWAIT
   } rw_state_e;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2
   } rw_acc_e;

   localparam int SYN_PRTAB_BIT  = 17;
   localparam int SYN_UNSUPP_BIT = 19;
   localparam int SYN_STORE_BIT  = 25;
   localparam int SYN_NOXL_BIT   = 30;

   localparam logic [63:0] PRTB_MASK  = 64'h0FFF_FFFF_FFFF_F000;
   localparam logic [63:0] ROOT_MASK  = 64'h0FFF_FFFF_FFFF_FF00;
   localparam logic [63:0] NLB_MASK   = 64'h00FF_FFFF_FFFF_FF00;
   localparam logic [63:0] RPN_MASK   = 64'h01FF_FFFF_FFFF_F000;
endpackage

// File: rtl/rw_bswap.sv
module rw_bswap #(
   parameter int BYTES = 8
) (
   input  logic [8*BYTES-1:0] din,
   output logic [8*BYTES-1:0] dout
);
   for (genvar i = 0; i < BYTES; i++) begin : g_byte
      assign dout[8*i +: 8] = din[8*(BYTES-1-i) +: 8];
   end
endmodule

// File: rtl/rw_entry_fields.sv
module rw_entry_fields
   import rw_pkg::*;
(
   input  logic [63:0] ent,
   output logic [63:0] prtb,
   output logic [63:0] root_base,
   output logic [4:0]  root_size,
   output logic [6:0]  useful,
   output logic        valid,
   output logic        leaf,
   output logic [63:0] nlb,
   output logic [4:0]  nls,
   output logic [63:0] rpn
);
   always_comb begin
      prtb      = ent & PRTB_MASK;
      root_base = ent & ROOT_MASK;
      root_size = ent[4:0];
      useful    = 7'd31 + {2'b00, ent[62:61], ent[7:5]};
      valid     = ent[63];
      leaf      = ent[62];
      nlb       = ent & NLB_MASK;
      nls       = ent[4:0];
      rpn       = ent & RPN_MASK;
   end
endmodule

// File: rtl/rw_level_addr.sv
module rw_level_addr #(
   parameter int AW = 64,
   parameter int UW = 7,
   parameter int SW = 5
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] ea,
   input  logic [UW-1:0] useful,
   input  logic [SW-1:0] size,
   output logic [AW-1:0] addr,
   output logic [AW-1:0] off_mask
);
   localparam int ENT_SHIFT = 3;
   logic [UW-1:0] shamt;
   logic [AW-1:0] idx;

   always_comb begin
      shamt    = useful - UW'(size);
      idx      = (ea >> shamt) & ((AW'(1) << size) - AW'(1));
      addr     = base + (idx << ENT_SHIFT);
      off_mask = (AW'(1) << shamt) - AW'(1);
   end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
   import rw_pkg::*;
#(
   parameter int MAX_LEVELS  = 4,
   parameter int MIN_LVL_SZ  = 5,
   parameter int TBL_ALIGN   = 12,
   parameter int LPID_W      = 12,
   parameter int PID_W       = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [63:0]       req_ea,
   input  logic [1:0]        req_mode,
   input  logic              msr_hv,
   input  logic              msr_pr,
   input  logic              msr_dr,
   input  logic              msr_ir,
   input  logic              lpcr_hr,
   input  logic [2:0]        lpcr_vc,
   input  logic [63:0]       ptab_base,
   input  logic [LPID_W-1:0] req_lpid,
   input  logic [PID_W-1:0]  req_pid,
   output logic              mem_req,
   output logic [63:0]       mem_addr,
   input  logic              mem_rvalid,
   input  logic [63:0]       mem_rdata,
   output logic              done,
   output logic              resp_fault,
   output logic [63:0]       resp_syndrome,
   output logic [63:0]       resp_ra,
   output logic [63:0]       resp_pte
);
   localparam int LVL_W = $clog2(MAX_LEVELS + 1);
   localparam int UW    = 7;
   localparam int SW    = 5;
   localparam logic [63:0] STORE_M = 64'd1 << SYN_STORE_BIT;

   if (MAX_LEVELS < 1 || MAX_LEVELS > 8) begin : g_bad_levels
      $error("MAX_LEVELS out of range");
   end
   if (MIN_LVL_SZ < 1 || MIN_LVL_SZ > 31) begin : g_bad_minsz
      $error("MIN_LVL_SZ out of range");
   end
   if (TBL_ALIGN < 3 || TBL_ALIGN > 32) begin : g_bad_align
      $error("TBL_ALIGN out of range");
   end

   rw_state_e        st_q;
   logic [63:0]      ea_q, base_q;
   logic             store_q, hr_q, dr_q, ir_q;
   logic [PID_W-1:0] pid_q;
   logic [SW-1:0]    size_q;
   logic [UW-1:0]    useful_q;
   logic [LVL_W-1:0] lvl_q;
   logic             mem_req_q, done_q, fault_q;
   logic [63:0]      mem_addr_q, syn_q, ra_q, pte_q;

   // byte reversal of every returned word
   logic [63:0] ent_sw;
   rw_bswap #(.BYTES(8)) u_bswap (.din(mem_rdata), .dout(ent_sw));

   logic [63:0]   f_prtb, f_root_base, f_nlb, f_rpn;
   logic [SW-1:0] f_root_size, f_nls;
   logic [UW-1:0] f_useful;
   logic          f_valid, f_leaf;
   rw_entry_fields u_fields (
      .ent(ent_sw), .prtb(f_prtb), .root_base(f_root_base),
      .root_size(f_root_size), .useful(f_useful), .valid(f_valid),
      .leaf(f_leaf), .nlb(f_nlb), .nls(f_nls), .rpn(f_rpn)
   );

   logic [63:0] lvl_addr, off_mask;
   rw_level_addr #(.AW(64), .UW(UW), .SW(SW)) u_laddr (
      .base(base_q), .ea(ea_q), .useful(useful_q), .size(size_q),
      .addr(lvl_addr), .off_mask(off_mask)
   );

   logic        pre_bad, lvl_bad;
   logic [63:0] pate_addr, store_or;
   always_comb begin
      pre_bad   = (!lpcr_hr && lpcr_vc <= 3'd3) || (msr_hv && !msr_pr && !msr_dr);
      pate_addr = (ptab_base & ~((64'd1 << TBL_ALIGN) - 64'd1))
                  + (64'(req_lpid) << 4) + 64'd8;
      lvl_bad   = (size_q < SW'(MIN_LVL_SZ)) || (lvl_q == LVL_W'(MAX_LEVELS))
                  || (UW'(size_q) > useful_q);
      store_or  = store_q ? STORE_M : 64'd0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         ea_q       <= '0;
         base_q     <= '0;
         store_q    <= 1'b0;
         hr_q       <= 1'b0;
         dr_q       <= 1'b0;
         ir_q       <= 1'b0;
         pid_q      <= '0;
         size_q     <= '0;
         useful_q   <= '0;
         lvl_q      <= '0;
         mem_req_q  <= 1'b0;
         mem_addr_q <= '0;
         done_q     <= 1'b0;
         fault_q    <= 1'b0;
         syn_q      <= '0;
         ra_q       <= '0;
         pte_q      <= '0;
      end else begin
         mem_req_q <= 1'b0;
         done_q    <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  ea_q    <= req_ea;
                  store_q <= (req_mode == ACC_STORE);
                  hr_q    <= lpcr_hr;
                  dr_q    <= msr_dr;
                  ir_q    <= msr_ir;
                  pid_q   <= req_pid;
                  if (pre_bad) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                     syn_q   <= (64'd1 << SYN_PRTAB_BIT)
                                | ((req_mode == ACC_STORE) ? STORE_M : 64'd0);
                     ra_q    <= req_ea;
                     pte_q   <= '0;
                  end else begin
                     mem_addr_q <= pate_addr;
                     mem_req_q  <= 1'b1;
                     st_q       <= ST_PATE;
                  end
               end
            end
            ST_PATE: begin
               if (mem_rvalid) begin
                  mem_addr_q <= f_prtb + (64'(pid_q) << 4);
                  mem_req_q  <= 1'b1;
                  st_q       <= ST_PRTE;
               end
            end
            ST_PRTE: begin
               if (mem_rvalid) begin
                  base_q   <= f_root_base;
                  size_q   <= f_root_size;
                  useful_q <= f_useful;
                  lvl_q    <= '0;
                  st_q     <= ST_LVL;
               end
            end
            ST_LVL: begin
               if (lvl_bad) begin
                  done_q  <= 1'b1;
                  fault_q <= 1'b1;
                  syn_q   <= (64'd1 << SYN_UNSUPP_BIT) | store_or;
                  ra_q    <= ea_q;
                  pte_q   <= '0;
                  st_q    <= ST_IDLE;
               end else begin
                  mem_addr_q <= lvl_addr;
                  mem_req_q  <= 1'b1;
                  st_q       <= ST_LWAIT;
               end
            end
            ST_LWAIT: begin
               if (mem_rvalid) begin
                  if (!f_valid) begin
                     done_q <= 1'b1;
                     ra_q   <= ea_q;
                     pte_q  <= '0;
                     st_q   <= ST_IDLE;
                     if (!hr_q) begin
                        fault_q <= 1'b1;
                        syn_q   <= (64'd1 << SYN_PRTAB_BIT) | store_or;
                     end else if (dr_q || ir_q) begin
                        fault_q <= 1'b1;
                        syn_q   <= (64'd1 << SYN_NOXL_BIT) | store_or;
                     end else begin
                        fault_q <= 1'b0;
                        syn_q   <= '0;
                     end
                  end else if (f_leaf) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b0;
                     syn_q   <= '0;
                     ra_q    <= (f_rpn & ~off_mask) | (ea_q & off_mask);
                     pte_q   <= ent_sw;
                     st_q    <= ST_IDLE;
                  end else begin
                     base_q   <= f_nlb;
                     size_q   <= f_nls;
                     useful_q <= useful_q - UW'(size_q);
                     lvl_q    <= lvl_q + 1'b1;
                     st_q     <= ST_LVL;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == ST_IDLE);
   assign mem_req       = mem_req_q;
   assign mem_addr      = mem_addr_q;
   assign done          = done_q;
   assign resp_fault    = fault_q;
   assign resp_syndrome = syn_q;
   assign resp_ra       = ra_q;
   assign resp_pte      = pte_q;

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R11
   single_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R11
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> $stable(mem_addr));
   // R1
   pre_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && ((!lpcr_hr && lpcr_vc <= 3'd3) || (msr_hv && !msr_pr && !msr_dr)))
      |=> (done && resp_fault && resp_syndrome[SYN_PRTAB_BIT] && !mem_req));
   // R12
   clean_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !resp_fault) |-> (resp_syndrome == 64'd0));
   // R10
   one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && resp_fault) |-> ($countones(resp_syndrome & ~STORE_M) == 1));
   // R6
   lvl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(lvl_q) <= MAX_LEVELS));
   // R5
   rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[2:0] == 3'b000));
endmodule

// File: tb/tb_radix_walker.sv
module tb_radix_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_ea = '0;
   logic [1:0]  req_mode = 2'd0;
   logic        msr_hv = 0, msr_pr = 1, msr_dr = 1, msr_ir = 1;
   logic        lpcr_hr = 1;
   logic [2:0]  lpcr_vc = 3'd0;
   logic [63:0] ptab_base = 64'h1000_0123;
   logic [11:0] req_lpid = 12'd2;
   logic [19:0] req_pid = 20'd3;
   logic        mem_req;
   logic [63:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        done, resp_fault;
   logic [63:0] resp_syndrome, resp_ra, resp_pte;

   radix_walker dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_ea(req_ea), .req_mode(req_mode), .msr_hv(msr_hv), .msr_pr(msr_pr),
      .msr_dr(msr_dr), .msr_ir(msr_ir), .lpcr_hr(lpcr_hr), .lpcr_vc(lpcr_vc),
      .ptab_base(ptab_base), .req_lpid(req_lpid), .req_pid(req_pid),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .done(done), .resp_fault(resp_fault),
      .resp_syndrome(resp_syndrome), .resp_ra(resp_ra), .resp_pte(resp_pte)
   );

   always #5 clk = ~clk;

   localparam logic [63:0] B17 = 64'h0000_0000_0002_0000;
   localparam logic [63:0] B19 = 64'h0000_0000_0008_0000;
   localparam logic [63:0] B25 = 64'h0000_0000_0200_0000;
   localparam logic [63:0] B30 = 64'h0000_0000_4000_0000;
   localparam logic [63:0] VAL = 64'h8000_0000_0000_0000;
   localparam logic [63:0] LEAF = 64'h4000_0000_0000_0000;

   int n_chk = 0, n_fail = 0;
   logic [63:0] mem [logic [63:0]];
   logic [63:0] rd_log [0:15];
   int rd_n = 0;
   int done_n = 0;
   logic [63:0] got_syn, got_ra, got_pte;
   logic got_fault;

   function automatic logic [63:0] bs(input logic [63:0] v);
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
      return r;
   endfunction

   function automatic logic [63:0] lvl_at(input logic [63:0] base, input logic [63:0] ea,
                                         input int u, input int s);
      logic [63:0] idx;
      idx = (ea >> (u - s)) & ((64'd1 << s) - 64'd1);
      return base + idx * 8;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%016h expected=0x%016h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [63:0] a, input logic [63:0] v);
      mem[a] = bs(v);
   endtask

   // memory responder: two-cycle latency, one answer per request
   initial begin
      int pend = 0;
      logic [63:0] a = '0;
      forever begin
         @(negedge clk);
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = mem.exists(a) ? mem[a] : 64'd0;
            end
         end else mem_rvalid = 1'b0;
         if (mem_req) begin
            a = mem_addr;
            if (rd_n < 16) rd_log[rd_n] = mem_addr;
            rd_n++;
            pend = 2;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (done) done_n++;
      end
   end

   task automatic ctx_ok();
      msr_hv = 0; msr_pr = 1; msr_dr = 1; msr_ir = 1;
      lpcr_hr = 1; lpcr_vc = 0; req_mode = 2'd0;
   endtask

   task automatic build_top(input logic [4:0] rts, input logic [4:0] rpds);
      mem.delete();
      put(64'h1000_0028, 64'h0000_0000_2000_0005);
      put(64'h2000_0030, ({62'd0, rts[4:3]} << 61) | ({61'd0, rts[2:0]} << 5)
                          | 64'h3000_0000 | {59'd0, rpds});
   endtask

   task automatic run(input logic [63:0] ea);
      rd_n = 0;
      req_ea = ea;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 300; i++) begin
         if (done) break;
         @(negedge clk);
      end
      chk(done == 1'b1, "R11 done seen", {63'd0, done}, 64'd1);
      got_fault = resp_fault; got_syn = resp_syndrome; got_ra = resp_ra; got_pte = resp_pte;
      @(negedge clk);
      chk(done == 1'b0, "R11 one-cycle done", {63'd0, done}, 64'd0);
   endtask

   task automatic t_reset();
      chk(done == 0 && mem_req == 0, "R12 reset outputs", {62'd0, done, mem_req}, 64'd0);
      chk(req_ready == 1, "R12 reset ready", {63'd0, req_ready}, 64'd1);
   endtask

   task automatic t_prefault();
      ctx_ok(); lpcr_hr = 0; lpcr_vc = 3'd2;
      run(64'h1234);
      chk(got_fault && got_syn == B17, "R1 hr/vc pre-fault", got_syn, B17);
      chk(rd_n == 0, "R1 no reads", 64'(rd_n), 64'd0);
      chk(got_ra == 64'h1234, "R12 fault ra=ea", got_ra, 64'h1234);
      ctx_ok(); msr_hv = 1; msr_pr = 0; msr_dr = 0; req_mode = 2'd1;
      run(64'h55);
      chk(got_fault && got_syn == (B17 | B25), "R10 store bit on hv pre-fault", got_syn, B17 | B25);
   endtask

   task automatic t_full_walk();
      logic [63:0] ea, a1, a2, a3, a4, rpn, exp_ra, leaf;
      ea = 64'h0001_2345_6789_ABCD;
      build_top(5'd21, 5'd13);
      a1 = lvl_at(64'h3000_0000, ea, 52, 13);
      a2 = lvl_at(64'h4100_0000, ea, 39, 9);
      a3 = lvl_at(64'h4200_0000, ea, 30, 9);
      a4 = lvl_at(64'h4300_0000, ea, 21, 9);
      put(a1, VAL | 64'h4100_0000 | 64'd9);
      put(a2, VAL | 64'h4200_0000 | 64'd9);
      put(a3, VAL | 64'h4300_0000 | 64'd9);
      rpn = 64'h0000_0055_6677_8000;
      leaf = VAL | LEAF | 64'h1000_0000_0000_0000 | rpn | 64'h7;
      put(a4, leaf);
      ctx_ok();
      run(ea);
      chk(rd_n == 6, "R9 six reads", 64'(rd_n), 64'd6);
      chk(rd_log[0] == 64'h1000_0028, "R2 partition entry addr", rd_log[0], 64'h1000_0028);
      chk(rd_log[1] == 64'h2000_0030, "R2 process entry addr", rd_log[1], 64'h2000_0030);
      chk(rd_log[2] == a1, "R4 R5 root level addr", rd_log[2], a1);
      chk(rd_log[3] == a2, "R9 level2 addr", rd_log[3], a2);
      chk(rd_log[5] == a4, "R9 level4 addr", rd_log[5], a4);
      exp_ra = rpn | (ea & 64'hFFF);
      chk(!got_fault && got_ra == exp_ra, "R8 R3 real address", got_ra, exp_ra);
      chk(got_pte == leaf, "R8 leaf out", got_pte, leaf);
      chk(got_syn == 0, "R12 clean syndrome", got_syn, 64'd0);
   endtask

   task automatic t_big_page();
      logic [63:0] ea, a1, a2, a3, rpn, m, exp_ra;
      ea = 64'h0000_7654_3210_FEDC;
      build_top(5'd21, 5'd13);
      a1 = lvl_at(64'h3000_0000, ea, 52, 13);
      a2 = lvl_at(64'h4100_0000, ea, 39, 9);
      a3 = lvl_at(64'h4200_0000, ea, 30, 9);
      put(a1, VAL | 64'h4100_0000 | 64'd9);
      put(a2, VAL | 64'h4200_0000 | 64'd9);
      rpn = 64'h0000_0077_0060_1000;
      put(a3, VAL | LEAF | rpn);
      ctx_ok();
      run(ea);
      m = 64'h1F_FFFF;
      exp_ra = (rpn & ~m) | (ea & m);
      chk(!got_fault && got_ra == exp_ra, "R8 large page offset", got_ra, exp_ra);
      chk(rd_n == 5, "R8 ends at leaf", 64'(rd_n), 64'd5);
   endtask

   task automatic t_invalid();
      logic [63:0] ea, a1;
      ea = 64'h0000_0000_8765_4000;
      build_top(5'd21, 5'd13);
      a1 = lvl_at(64'h3000_0000, ea, 52, 13);
      put(a1, VAL | 64'h4100_0000 | 64'd9);
      ctx_ok(); lpcr_hr = 0; lpcr_vc = 3'd5;
      run(ea);
      chk(got_fault && got_syn == B17, "R7 invalid hr=0", got_syn, B17);
      ctx_ok(); req_mode = 2'd1;
      run(ea);
      chk(got_fault && got_syn == (B30 | B25), "R7 R10 no translation store", got_syn, B30 | B25);
      ctx_ok(); msr_dr = 0; msr_ir = 0;
      run(ea);
      chk(!got_fault && got_ra == ea && got_syn == 0, "R7 relocation off passes", got_ra, ea);
   endtask

   task automatic t_unsupp();
      logic [63:0] ea, a1, a2, a3, a4;
      ea = 64'h0000_ABCD_0123_4567;
      build_top(5'd21, 5'd4);
      ctx_ok();
      run(ea);
      chk(got_fault && got_syn == B19, "R6 root too small", got_syn, B19);
      chk(rd_n == 2, "R6 no level read", 64'(rd_n), 64'd2);
      build_top(5'd21, 5'd13);
      a1 = lvl_at(64'h3000_0000, ea, 52, 13);
      a2 = lvl_at(64'h4100_0000, ea, 39, 9);
      a3 = lvl_at(64'h4200_0000, ea, 30, 9);
      a4 = lvl_at(64'h4300_0000, ea, 21, 5);
      put(a1, VAL | 64'h4100_0000 | 64'd9);
      put(a2, VAL | 64'h4200_0000 | 64'd9);
      put(a3, VAL | 64'h4300_0000 | 64'd5);
      put(a4, VAL | 64'h4400_0000 | 64'd5);
      run(ea);
      chk(got_fault && got_syn == B19, "R6 depth cap", got_syn, B19);
      chk(rd_n == 6, "R6 depth cap reads", 64'(rd_n), 64'd6);
      build_top(5'd0, 5'd13);
      a1 = lvl_at(64'h3000_0000, ea, 31, 13);
      put(a1, VAL | 64'h4100_0000 | 64'd20);
      req_mode = 2'd2;
      run(ea);
      chk(got_fault && got_syn == B19, "R6 width over remaining", got_syn, B19);
      chk(rd_n == 3, "R6 width reads", 64'(rd_n), 64'd3);
   endtask

   task automatic t_busy();
      logic [63:0] ea;
      int d0;
      ea = 64'h0001_2345_6789_ABCD;
      ctx_ok();
      build_top(5'd21, 5'd4);
      d0 = done_n;
      rd_n = 0;
      req_ea = ea; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk(req_ready == 0, "R11 busy not ready", {63'd0, req_ready}, 64'd0);
      req_ea = 64'h99; lpcr_hr = 0; lpcr_vc = 0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; ctx_ok();
      repeat (40) @(negedge clk);
      chk(done_n - d0 == 1, "R11 single response", 64'(done_n - d0), 64'd1);
      chk(rd_n == 2, "R11 busy request ignored", 64'(rd_n), 64'd2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prefault();
      t_full_walk();
      t_big_page();
      t_invalid();
      t_unsupp();
      t_busy();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule